// File: doc/BRIEF.md
# Interrupt Rate Limiter

This block sits on a single raw interrupt request line in front of the processor and limits how often that line can interrupt it. The raw line is synchronized and edge-detected, and each rising edge counts as one request. A request is forwarded as a one-cycle pulse only when the spacing down-counter is idle (zero) and both enables are set. Forwarding a request loads the counter with the programmed spacing value. The counter then counts down on a divided tick. No clock is divided; the tick only enables the decrement.

Requests that arrive while the counter is still running, or while either enable is low, are discarded. They are not held back for later. A saturating counter records each discarded request, so a chattering source can be found. Two separate enables control forwarding. One belongs to the overload scheduler and one to the programmer, so software can mask the line without disturbing the limiter's own control.

Top module: `irq_rate_gate`

## Requirements
- R1: After reset `irq_fwd` is 0, `drop_cnt` is 0 and the spacing counter is idle. A first rising edge on `irq_raw` that is set up before clock edge k, with both enables high, drives `irq_fwd` high after clock edge k+2.
- R2: Each rising edge of `irq_raw` is one request. `irq_fwd` is never high for two cycles in a row, and a level held high produces at most one pulse.
- R3: A forwarded request loads the spacing counter with `gap_reload`. The counter decrements once every `TICK_DIV` clocks (default 4), and no request is forwarded while it is non-zero. With reload N, the next pass is possible between 4N-3 and 4N clocks after the forwarding edge.
- R4: Requests that arrive inside a spacing window are discarded and produce no later pulse.
- R5: A `gap_reload` of 0 disables limiting: every request with both enables high is forwarded.
- R6: A request is forwarded only when both `sched_en` and `prog_en` are 1. With either enable at 0, the request is dropped and counted.
- R7: `drop_cnt` increments by one for each suppressed request and saturates at all ones (255 for the default width).
- R8: `drop_clr` at 1 clears `drop_cnt` on the next clock edge and takes priority over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_raw | input | 1 | Raw asynchronous interrupt request |
| gap_reload | input | SPACE_W | Spacing reload value, in ticks |
| sched_en | input | 1 | Overload scheduler enable |
| prog_en | input | 1 | Programmer enable |
| drop_clr | input | 1 | Clear the drop counter |
| irq_fwd | output | 1 | Forwarded one-cycle interrupt pulse |
| drop_cnt | output | DROP_W | Saturating count of suppressed requests |

## Verification
Edge trains are driven at spacings that fall clearly inside or clearly outside the window of uncertainty caused by the tick phase. A fast train against a long reload shows that only one request per window passes. A train slower than the window shows that nothing is lost when the source behaves. A medium train shows that passes alternate with drops at the expected ratio. A zero reload and each enable held low separate the "no limiting" case from the "everything masked" case. A long masked burst, a clear that coincides with a request, and a held-high level check saturation, clear priority and single-pulse forwarding.

// File: rtl/irq_rate_gate.sv
module irq_rate_gate #(
  parameter int SPACE_W  = 16,
  parameter int DROP_W   = 8,
  parameter int TICK_DIV = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               irq_raw,
  input  logic [SPACE_W-1:0] gap_reload,
  input  logic               sched_en,
  input  logic               prog_en,
  input  logic               drop_clr,
  output logic               irq_fwd,
  output logic [DROP_W-1:0]  drop_cnt
);

  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);
  localparam logic [DROP_W-1:0] DROP_MAX = '1;

  logic [2:0]         sync_q;
  logic [PW-1:0]      pre_cnt;
  logic [SPACE_W-1:0] gap_cnt;

  wire req   = sync_q[1] & ~sync_q[2];
  wire tick  = (pre_cnt == PRE_LAST);
  wire pass  = (gap_cnt == '0) & sched_en & prog_en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], irq_raw};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    pre_cnt <= '0;
    else if (tick) pre_cnt <= '0;
    else           pre_cnt <= pre_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                       gap_cnt <= '0;
    else if (req && pass)             gap_cnt <= gap_reload;
    else if (tick && gap_cnt != '0)   gap_cnt <= gap_cnt - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq_fwd <= 1'b0;
    else        irq_fwd <= req & pass;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                  drop_cnt <= '0;
    else if (drop_clr)                           drop_cnt <= '0;
    else if (req && !pass && drop_cnt != DROP_MAX) drop_cnt <= drop_cnt + 1'b1;

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fwd |=> !irq_fwd);

  a_r3_reload_on_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fwd |-> gap_cnt == $past(gap_reload));

  a_r3_window_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_cnt != '0) |=> !irq_fwd);

  a_r6_both_enables: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fwd |-> $past(sched_en && prog_en));

  a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_cnt == DROP_MAX && !drop_clr) |=> drop_cnt == DROP_MAX);

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    drop_clr |=> drop_cnt == '0);

endmodule

// File: tb/sim_irq_rate_gate.sv
module sim_irq_rate_gate;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  // reload, sched, prog, edges, spacing, expected forwards, expected drops
  localparam int V_RLD [NV] = '{10, 2, 0, 4, 4, 3};
  localparam int V_SCH [NV] = '{ 1, 1, 1, 0, 1, 1};
  localparam int V_PRG [NV] = '{ 1, 1, 1, 1, 0, 1};
  localparam int V_NED [NV] = '{10, 5, 6, 4, 4, 8};
  localparam int V_SPC [NV] = '{ 6,12, 6, 6, 6, 7};
  localparam int V_FWD [NV] = '{ 2, 5, 6, 0, 0, 4};
  localparam int V_DRP [NV] = '{ 8, 0, 0, 4, 4, 4};

  logic clk = 0, rst_n = 0, irq_raw = 0, sched_en = 1, prog_en = 1, drop_clr = 0;
  logic [15:0] gap_reload = '0;
  logic irq_fwd;
  logic [7:0] drop_cnt;
  int checks = 0, failures = 0, fwd_seen = 0;

  irq_rate_gate u0 (.clk(clk), .rst_n(rst_n), .irq_raw(irq_raw), .gap_reload(gap_reload),
    .sched_en(sched_en), .prog_en(prog_en), .drop_clr(drop_clr),
    .irq_fwd(irq_fwd), .drop_cnt(drop_cnt));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) if (irq_fwd) fwd_seen++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic edges(input int n, input int spc);
    for (int i = 0; i < n; i++) begin
      irq_raw = 1; cycles(2);
      irq_raw = 0; cycles(spc - 2);
    end
  endtask

  task automatic clear_drops;
    drop_clr = 1; cycles(1); drop_clr = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    cycles(3);
    check("R1 reset fwd", irq_fwd, 0);
    check("R1 reset drops", drop_cnt, 0);
    rst_n = 1;
    cycles(2);
    // R1 first request forwarded after 3 edges
    gap_reload = 16'd10;
    irq_raw = 1;
    @(posedge clk); @(posedge clk); @(posedge clk); @(negedge clk);
    check("R1 first pass latency", irq_fwd, 1);
    cycles(1);
    check("R2 pulse width", irq_fwd, 0);
    irq_raw = 0;
    cycles(60);

    for (int v = 0; v < NV; v++) begin
      gap_reload = 16'(V_RLD[v]); sched_en = V_SCH[v][0]; prog_en = V_PRG[v][0];
      clear_drops();
      fwd_seen = 0;
      edges(V_NED[v], V_SPC[v]);
      cycles(84);
      check($sformatf("R3 R4 R5 R6 vector %0d forwards", v), fwd_seen, V_FWD[v]);
      check($sformatf("R6 R7 vector %0d drops", v), drop_cnt, V_DRP[v]);
    end

    // R2 held level gives one pulse
    gap_reload = 16'd0; sched_en = 1; prog_en = 1;
    fwd_seen = 0;
    irq_raw = 1; cycles(30); irq_raw = 0; cycles(5);
    check("R2 held level one pulse", fwd_seen, 1);

    // R7 saturation
    sched_en = 0;
    clear_drops();
    edges(300, 5);
    cycles(5);
    check("R7 saturate at 255", drop_cnt, 255);

    // R8 clear wins over increment
    drop_clr = 1;
    edges(1, 6);
    drop_clr = 0;
    cycles(2);
    check("R8 clear priority", drop_cnt, 0);
    edges(1, 6);
    cycles(2);
    check("R8 counting resumes", drop_cnt, 1);

    // R1 reset in mid-window restores idle counter
    sched_en = 1; gap_reload = 16'd100;
    fwd_seen = 0;
    edges(1, 6);
    check("R3 long window pass", fwd_seen, 1);
    rst_n = 0; cycles(2);
    check("R1 reset clears drops", drop_cnt, 0);
    rst_n = 1; cycles(2);
    irq_raw = 1;
    @(posedge clk); @(posedge clk); @(posedge clk); @(negedge clk);
    check("R1 pass after reset", irq_fwd, 1);
    irq_raw = 0;
    cycles(4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule